// File: doc/BRIEF.md
# EEPROM Page Write Sequencer

This block sits between an I2C target front end and a 256-byte memory array. The front end hands it a word address, then a stream of received data bytes. The block keeps the upper four address bits as the page and places each byte in a 16-entry page buffer. It records which buffer slots were loaded and advances a 4-bit slot pointer that wraps inside the page. Nothing reaches the array until the front end reports STOP.

On an accepted STOP, the block starts an internal write cycle and raises `busy` for a fixed number of system clocks (`WRITE_CYCLES`). During the first sixteen cycles of that window, it scans the slots in ascending order and issues one byte-write strobe for every loaded slot. While `busy` is high, every new address, data byte and STOP is ignored, so the front end can withhold its acknowledge.

An abort input ends the cycle at once. A protection decision made elsewhere arrives as a write-enable level: if that level is low at STOP, the loaded bytes are discarded. The array is included, with a read port, and every location comes out of reset as FFh.

Top module: `page_write_sequencer`

## Requirements
- R1: After reset, every one of the 256 locations reads FFh on `rd_data` and `busy` is low.
- R2: `addr_in[7:4]` selects the page and `addr_in[3:0]` the first slot. Each accepted data byte lands at slot = pointer, then only the 4-bit pointer increments (0xF wraps to 0x0), and the page bits never change within a transaction.
- R3: When more than 16 bytes arrive before STOP, each slot holds the last byte written to it, and that last byte is what gets committed.
- R4: Before an accepted STOP, the array is unchanged. A commit writes only the loaded slots of the page, and every other location keeps its previous value.
- R5: An accepted STOP raises `busy` in the cycle after the STOP strobe and holds it for exactly `WRITE_CYCLES` cycles. Loaded slot k is written on the k-th clock edge after the STOP edge (k = 1 for slot 0, ascending order).
- R6: While `busy` is high, `addr_load`, `data_valid` and `stop_strobe` have no effect. In particular, after the cycle ends no byte is pending, so a later STOP starts nothing.
- R7: `abort_in` high while busy drops `busy` on the next cycle. No write occurs in that cycle or later, and slots not yet written keep their old contents.
- R8: A STOP with `wr_enable` low, or with no byte loaded since the last address, writes nothing and does not raise `busy`.
- R9: `abort_in` while idle discards all loaded bytes, so a following STOP writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_load | input | 1 | Strobe: word address received |
| addr_in | input | 8 | Word address (page in [7:4], slot in [3:0]) |
| data_valid | input | 1 | Strobe: data byte received |
| data_in | input | 8 | Received data byte |
| stop_strobe | input | 1 | Strobe: STOP seen on the bus |
| abort_in | input | 1 | Cancel pending bytes or the running write cycle |
| wr_enable | input | 1 | Write permission level, sampled with STOP |
| rd_addr | input | 8 | Array read address |
| rd_data | output | 8 | Array read data (combinational) |
| busy | output | 1 | Internal write cycle in progress |
| mem_we | output | 1 | Byte-write strobe into the array |
| mem_addr | output | 8 | Byte-write address |
| mem_wdata | output | 8 | Byte-write data |

## Verification
The bench builds the block with `WRITE_CYCLES` = 40 instead of the default of one million. This keeps every write window short enough to count cycle by cycle. It also puts an abort at a chosen scan position, and so a chosen number of committed slots, within easy reach. The page and slot widths keep their defaults, so pointer wrap, overwrite beyond 16 bytes and random page and offset mixes all land on the real 16-slot geometry.

// File: rtl/epw_pkg.sv
`timescale 1ns/1ps
package epw_pkg;
  localparam int unsigned EPW_ADDR_W = 8;
  localparam int unsigned EPW_DATA_W = 8;
  localparam int unsigned EPW_SLOT_W = 4;

  typedef enum logic [0:0] {
    WS_IDLE    = 1'b0,
    WS_PROGRAM = 1'b1
  } wstate_e;
endpackage

// File: rtl/epw_page_buffer.sv
`timescale 1ns/1ps
module epw_page_buffer #(
  parameter int unsigned ADDR_W = epw_pkg::EPW_ADDR_W,
  parameter int unsigned DATA_W = epw_pkg::EPW_DATA_W,
  parameter int unsigned SLOT_W = epw_pkg::EPW_SLOT_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept_en,
  input  logic                     clear,
  input  logic                     addr_load,
  input  logic [ADDR_W-1:0]        addr_in,
  input  logic                     data_valid,
  input  logic [DATA_W-1:0]        data_in,
  input  logic [SLOT_W-1:0]        rd_slot,
  output logic [ADDR_W-SLOT_W-1:0] page_q,
  output logic [(1<<SLOT_W)-1:0]   mask_q,
  output logic [DATA_W-1:0]        rd_data
);
  localparam int unsigned PAGE_W = ADDR_W - SLOT_W;
  localparam int unsigned SLOTS  = 1 << SLOT_W;

  logic [PAGE_W-1:0] page_d;
  logic [SLOT_W-1:0] ptr_q, ptr_d;
  logic [SLOTS-1:0]  mask_d;
  logic              take_addr, take_byte;
  logic [DATA_W-1:0] slot_bus [SLOTS];

  assign take_addr = accept_en && addr_load && !clear;
  assign take_byte = accept_en && data_valid && !addr_load && !clear;

  always_comb begin
    page_d = page_q;
    ptr_d  = ptr_q;
    mask_d = mask_q;
    if (clear) begin
      mask_d = '0;
    end else if (take_addr) begin
      page_d = addr_in[ADDR_W-1:SLOT_W];
      ptr_d  = addr_in[SLOT_W-1:0];
      mask_d = '0;
    end else if (take_byte) begin
      mask_d[ptr_q] = 1'b1;
      ptr_d         = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      ptr_q  <= '0;
      mask_q <= '0;
    end else begin
      page_q <= page_d;
      ptr_q  <= ptr_d;
      mask_q <= mask_d;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic              wr_en;
    logic [DATA_W-1:0] data_q;
    assign wr_en = take_byte && (ptr_q == SLOT_W'(s));
    always_ff @(posedge clk) begin
      if (wr_en) data_q <= data_in;
    end
    assign slot_bus[s] = data_q;
  end

  assign rd_data = slot_bus[rd_slot];

  // R2: a stored byte never moves the page
  a_r2_page_held: assert property (@(posedge clk) disable iff (!rst_n)
    take_byte |=> $stable(page_q));
  // R2: the slot that took the byte is flagged as loaded
  a_r2_slot_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    take_byte |=> mask_q[$past(ptr_q)]);
endmodule

// File: rtl/epw_write_timer.sv
`timescale 1ns/1ps
module epw_write_timer #(
  parameter int unsigned WRITE_CYCLES = 1000000,
  parameter int unsigned SLOT_W       = epw_pkg::EPW_SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  output logic              busy,
  output logic              scan_valid,
  output logic [SLOT_W-1:0] scan_slot,
  output logic              done
);
  localparam int unsigned SLOTS = 1 << SLOT_W;
  localparam int unsigned CNT_W = (WRITE_CYCLES > 2) ? $clog2(WRITE_CYCLES) : 1;

  epw_pkg::wstate_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign busy       = (state_q == epw_pkg::WS_PROGRAM);
  assign done       = busy && (cnt_q == CNT_W'(WRITE_CYCLES - 1));
  assign scan_valid = busy && (32'(cnt_q) < SLOTS);
  assign scan_slot  = cnt_q[SLOT_W-1:0];

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      epw_pkg::WS_IDLE: begin
        if (start) begin
          state_d = epw_pkg::WS_PROGRAM;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      epw_pkg::WS_PROGRAM: begin
        if (abort || done) begin
          state_d = epw_pkg::WS_IDLE;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: state_d = epw_pkg::WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= epw_pkg::WS_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R5: each write window begins at the first scan position
  a_r5_window_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (scan_slot == '0) && scan_valid);
  // R7: abort ends the window on the next cycle
  a_r7_abort_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && abort |=> !busy);
endmodule

// File: rtl/epw_cell_array.sv
`timescale 1ns/1ps
module epw_cell_array #(
  parameter int unsigned ADDR_W = epw_pkg::EPW_ADDR_W,
  parameter int unsigned DATA_W = epw_pkg::EPW_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] cell_q [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) cell_q[i] <= '1;
    end else if (we) begin
      cell_q[waddr] <= wdata;
    end
  end

  assign rdata = cell_q[raddr];
endmodule

// File: rtl/page_write_sequencer.sv
`timescale 1ns/1ps
module page_write_sequencer #(
  parameter int unsigned ADDR_W       = epw_pkg::EPW_ADDR_W,
  parameter int unsigned DATA_W       = epw_pkg::EPW_DATA_W,
  parameter int unsigned SLOT_W       = epw_pkg::EPW_SLOT_W,
  parameter int unsigned WRITE_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              data_valid,
  input  logic [DATA_W-1:0] data_in,
  input  logic              stop_strobe,
  input  logic              abort_in,
  input  logic              wr_enable,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int unsigned PAGE_W = ADDR_W - SLOT_W;
  localparam int unsigned SLOTS  = 1 << SLOT_W;

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic              start, clear, done, scan_valid;
  logic [SLOT_W-1:0] scan_slot;
  logic [PAGE_W-1:0] page_q;
  logic [SLOTS-1:0]  mask_q;
  logic [DATA_W-1:0] slot_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign start = !busy && stop_strobe && wr_enable && !abort_in && (|mask_q);
  assign clear = done || (busy && abort_in)
               || (!busy && (abort_in || (stop_strobe && !start)));

  epw_page_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_buffer (
    .clk(clk), .rst_n(rst_sync_n), .accept_en(!busy), .clear(clear),
    .addr_load(addr_load), .addr_in(addr_in),
    .data_valid(data_valid), .data_in(data_in),
    .rd_slot(scan_slot), .page_q(page_q), .mask_q(mask_q), .rd_data(slot_data)
  );

  epw_write_timer #(.WRITE_CYCLES(WRITE_CYCLES), .SLOT_W(SLOT_W)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .abort(abort_in),
    .busy(busy), .scan_valid(scan_valid), .scan_slot(scan_slot), .done(done)
  );

  assign mem_we    = scan_valid && mask_q[scan_slot] && !abort_in;
  assign mem_addr  = {page_q, scan_slot};
  assign mem_wdata = slot_data;

  epw_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_sync_n), .we(mem_we), .waddr(mem_addr),
    .wdata(mem_wdata), .raddr(rd_addr), .rdata(rd_data)
  );

  // R4: array strobes only inside a write window
  a_r4_write_only_busy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_we |-> busy);
  // R4: a window only opens after a STOP strobe
  a_r4_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy) |-> $past(stop_strobe));
  // R6: the page stays frozen through the window
  a_r6_page_frozen: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |=> $stable(page_q));
  // R7: no strobe after an abort
  a_r7_no_write_after_abort: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy && abort_in |=> !mem_we);
  // R8: a disabled STOP never opens a window
  a_r8_disabled_stop: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy && stop_strobe && !wr_enable |=> !busy);
endmodule

// File: tb/page_write_sequencer_tb.sv
`timescale 1ns/1ps
module page_write_sequencer_tb_top;
  localparam int WC = 40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       addr_load, data_valid, stop_strobe, abort_in, wr_enable;
  logic [7:0] addr_in, data_in, rd_addr, rd_data, mem_addr, mem_wdata;
  logic       busy, mem_we;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_mem [256];

  always #2.5 clk = ~clk;

  page_write_sequencer #(.WRITE_CYCLES(WC)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .data_valid(data_valid), .data_in(data_in), .stop_strobe(stop_strobe),
    .abort_in(abort_in), .wr_enable(wr_enable), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_addr(input logic [7:0] a);
    @(negedge clk); addr_load = 1'b1; addr_in = a;
    @(negedge clk); addr_load = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk); data_valid = 1'b1; data_in = d;
    @(negedge clk); data_valid = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_strobe = 1'b1;
    @(negedge clk); stop_strobe = 1'b0;
  endtask

  task automatic pulse_abort();
    @(negedge clk); abort_in = 1'b1;
    @(negedge clk); abort_in = 1'b0;
  endtask

  task automatic read_mem(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a; #1; d = rd_data;
  endtask

  task automatic check_page(input logic [3:0] page, input string req);
    logic [7:0] d;
    for (int s = 0; s < 16; s++) begin
      read_mem({page, 4'(s)}, d);
      check(d == exp_mem[{page, 4'(s)}], req, d, exp_mem[{page, 4'(s)}]);
    end
  endtask

  // count busy cycles starting at the negedge right after the STOP edge
  task automatic count_busy(output int c);
    c = 0;
    while (busy && c < 1000) begin c++; @(negedge clk); end
  endtask

  task automatic run_write(input logic [3:0] page, input logic [3:0] start,
                           input int n, input bit wren, input bit pre_check);
    logic [7:0] bufv [16];
    bit         msk  [16];
    logic [3:0] slot;
    logic [7:0] d;
    int         c;
    slot = start;
    for (int s = 0; s < 16; s++) begin msk[s] = 1'b0; bufv[s] = 8'h00; end
    wr_enable = wren;
    send_addr({page, start});
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d);
      bufv[slot] = d; msk[slot] = 1'b1; slot = slot + 4'd1;
    end
    if (pre_check) check_page(page, "R4 before STOP");
    pulse_stop();
    if (wren && n > 0) begin
      count_busy(c);
      check(c == WC, "R5 busy length", c, WC);
      for (int s = 0; s < 16; s++) if (msk[s]) exp_mem[{page, 4'(s)}] = bufv[s];
      check_page(page, (n > 16) ? "R3 overwrite" : "R2 placement");
    end else begin
      check(busy == 1'b0, "R8 no busy", busy, 0);
      check_page(page, "R8 unchanged");
    end
    wr_enable = 1'b1;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int         c;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; addr_load = 0; data_valid = 0; stop_strobe = 0; abort_in = 0;
    wr_enable = 1'b1; addr_in = 0; data_in = 0; rd_addr = 0;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset contents and idle state
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    for (int a = 0; a < 256; a++) begin
      read_mem(8'(a), d);
      check(d == 8'hFF, "R1 reset content", d, 8'hFF);
    end

    // R2/R4/R5: single byte, then wrap across slot F to 0
    run_write(4'h3, 4'h5, 1, 1'b1, 1'b1);
    run_write(4'hA, 4'hE, 4, 1'b1, 1'b1);
    // R3: 20 bytes into a 16-slot page
    run_write(4'h2, 4'h0, 20, 1'b1, 1'b1);
    // R8: disabled write and address-only STOP
    run_write(4'h4, 4'h1, 6, 1'b0, 1'b0);
    run_write(4'h5, 4'h7, 0, 1'b1, 1'b0);

    // R6: strobes during the window are ignored
    send_addr(8'h60);
    send_byte(8'h11); send_byte(8'h22);
    pulse_stop();
    send_addr(8'h70); send_byte(8'h99); pulse_stop();
    send_byte(8'h98);
    while (busy) @(negedge clk);
    exp_mem[8'h60] = 8'h11; exp_mem[8'h61] = 8'h22;
    check_page(4'h6, "R6 target page");
    check_page(4'h7, "R6 stray page untouched");
    pulse_stop();
    check(busy == 1'b0, "R6 nothing pending", busy, 0);

    // R7: abort after five scan cycles, slots 0..4 committed
    send_addr(8'h90);
    for (int s = 0; s < 16; s++) send_byte(8'hC0 + 8'(s));
    pulse_stop();
    repeat (5) @(negedge clk);
    abort_in = 1'b1;
    @(negedge clk); abort_in = 1'b0;
    check(busy == 1'b0, "R7 busy dropped", busy, 0);
    for (int s = 0; s < 5; s++) exp_mem[8'h90 + 8'(s)] = 8'hC0 + 8'(s);
    repeat (50) @(negedge clk);
    check_page(4'h9, "R7 partial commit");

    // R9: idle abort discards loaded bytes
    send_addr(8'hB3); send_byte(8'h5A); send_byte(8'hA5);
    pulse_abort();
    pulse_stop();
    check(busy == 1'b0, "R9 no busy after idle abort", busy, 0);
    check_page(4'hB, "R9 page unchanged");

    // random mix
    for (int t = 0; t < 20; t++) begin
      run_write(4'($urandom), 4'($urandom), int'($urandom % 25),
                ($urandom % 5) != 0, ($urandom % 2) == 0);
    end

    // R5: a full-page commit still takes exactly the window length
    send_addr(8'hF0);
    for (int s = 0; s < 16; s++) begin
      send_byte(8'(s * 3));
      exp_mem[8'hF0 + 8'(s)] = 8'(s * 3);
    end
    pulse_stop();
    count_busy(c);
    check(c == WC, "R5 full page busy length", c, WC);
    check_page(4'hF, "R4 full page");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule